// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Synchronizers

This block is a first-in first-out buffer that joins a producer running on its own write clock and a consumer on an independent read clock. Each side has its own view of the buffer: a full flag, an empty flag and a count of stored words. The two views are kept consistent by sending each side's pointer into the other domain as a Gray-coded value through a chain of flip-flops whose length is set by the `SYNC_STAGES` parameter.

Every flag and count changes at a fixed cycle after the request that moved it. The delay is counted in local clock cycles, plus synchronizer cycles of the far clock where the change has to cross. A view from the far side always lags the true fill. This makes the lag safe: full can stay high too long and empty can stay high too long, but a write into a full buffer or a read from an empty one can never slip through. Read data is registered and appears one read-clock cycle after an accepted read.

Top module: `dcf_fifo`

## Requirements
- R1: A write is taken on a `wclk` rising edge when `wreq` is 1 and `wfull` is 0, storing `wdata`; reads return the stored words in the order they were written.
- R2: `wfull` and `wempty` reflect a taken write one `wclk` cycle after the edge that took it; `wfull` is 1 when the write-side count of words reaches 2^`ADDR_W`.
- R3: `wused` (number of words, `ADDR_W`+1 bits) reflects a taken write two `wclk` cycles after the request edge.
- R4: `rempty` and `rfull` reflect a write after two `wclk` cycles followed by `SYNC_STAGES` `rclk` rising edges.
- R5: `rused` reflects a write after two `wclk` cycles followed by `SYNC_STAGES`+1 `rclk` rising edges.
- R6: A read is taken on an `rclk` rising edge when `rreq` is 1 and `rempty` is 0; the word appears on `rdata` one `rclk` cycle later, and `rdata` holds its value when no read is taken.
- R7: `rempty` and `rfull` reflect a taken read one `rclk` cycle after the request edge; `rused` reflects it two `rclk` cycles after.
- R8: `wempty` and `wfull` reflect a read after one `rclk` cycle followed by `SYNC_STAGES` `wclk` rising edges; `wused` reflects it after one `rclk` cycle followed by `SYNC_STAGES`+1 `wclk` edges.
- R9: A write while `wfull` is 1 stores nothing and leaves the counts unchanged. A read while `rempty` is 1 leaves `rdata` and the counts unchanged.
- R10: Pointers cross the domains in Gray code, changing at most one bit per cycle, and neither side's count ever exceeds 2^`ADDR_W`.
- R11: While a side is in reset and after reset is released, its empty flag is 1, its full flag is 0 and its count is 0; `rdata` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain asynchronous reset, active low |
| wreq | input | 1 | Write request |
| wdata | input | DATA_W | Word to store |
| wfull | output | 1 | Write-side full flag |
| wempty | output | 1 | Write-side empty flag |
| wused | output | ADDR_W+1 | Write-side count of stored words |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain asynchronous reset, active low |
| rreq | input | 1 | Read request |
| rdata | output | DATA_W | Registered read word |
| rfull | output | 1 | Read-side full flag |
| rempty | output | 1 | Read-side empty flag |
| rused | output | ADDR_W+1 | Read-side count of stored words |

## Verification
The hardest case to reach is the exact cycle at which a flag in one domain moves in answer to a request in the other. If the two clock edges land close together, the count of synchronizer cycles becomes ambiguous. The bench therefore runs the read clock at a period that is not a multiple of the write clock and puts its edges on half-nanosecond offsets, so the two edges never coincide. It then counts far-clock edges one by one from a single write or read, checking the flag just before and just after the expected edge. Random phases, first weighted toward writing and then toward reading, hold the buffer near full and near empty while the two sides race.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Widest pointer the conversion helpers handle; callers cast down.
    localparam int unsigned DCF_PTR_MAX = 32;

    typedef logic [DCF_PTR_MAX-1:0] dcf_ptr_t;

    // Binary count to reflected Gray code.
    function automatic dcf_ptr_t bin2gray(dcf_ptr_t b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary: prefix XOR from the top bit.
    function automatic dcf_ptr_t gray2bin(dcf_ptr_t g);
        dcf_ptr_t b;
        b[DCF_PTR_MAX-1] = g[DCF_PTR_MAX-1];
        for (int i = DCF_PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wclk_i,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rclk_i,
    input  logic              rrst_ni,
    input  logic              ren_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk_i) begin
        if (wen_i) store[waddr_i] <= wdata_i;
    end

    always_comb begin
        rdata_d = ren_i ? store[raddr_i] : rdata_q;
    end

    always_ff @(posedge rclk_i or negedge rrst_ni) begin
        if (!rrst_ni) rdata_q <= '0;
        else          rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_req_i,
    input  logic [ADDR_W:0]   peer_gray_i,
    output logic              full_o,
    output logic              empty_o,
    output logic [ADDR_W:0]   level_o,
    output logic              wen_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [ADDR_W:0]   gray_tx_o
);

    localparam int unsigned PW    = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] tx;
        logic [PW-1:0] level;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [PW-1:0] peer_bin;
    logic [PW-1:0] full_pat;
    logic          push;

    always_comb begin
        peer_bin = PW'(gray2bin(dcf_ptr_t'(peer_gray_i)));
        full_pat = {~peer_gray_i[PW-1:PW-2], peer_gray_i[PW-3:0]};
        full_o   = (st_q.gray == full_pat);
        empty_o  = (st_q.gray == peer_gray_i);
        push     = push_req_i && !full_o;

        st_d       = st_q;
        st_d.bin   = st_q.bin + PW'(push);
        st_d.gray  = PW'(bin2gray(dcf_ptr_t'(st_d.bin)));
        st_d.tx    = st_q.gray;
        st_d.level = st_q.bin - peer_bin;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o   = st_q.level;
    assign wen_o     = push;
    assign waddr_o   = st_q.bin[ADDR_W-1:0];
    assign gray_tx_o = st_q.tx;

    // R10: the local Gray pointer moves by at most one bit per cycle
    p_wgray_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);

    // R9: against the lagging peer pointer the fill never passes the depth
    p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.bin - peer_bin) <= PW'(DEPTH));

    // R3: the registered count stays in range
    p_wlevel_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.level <= PW'(DEPTH));

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pop_req_i,
    input  logic [ADDR_W:0]   peer_gray_i,
    output logic              full_o,
    output logic              empty_o,
    output logic [ADDR_W:0]   level_o,
    output logic              ren_o,
    output logic [ADDR_W-1:0] raddr_o,
    output logic [ADDR_W:0]   gray_o
);

    localparam int unsigned PW    = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] level;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] peer_bin;
    logic [PW-1:0] full_pat;
    logic          pop;

    always_comb begin
        peer_bin = PW'(gray2bin(dcf_ptr_t'(peer_gray_i)));
        full_pat = {~st_q.gray[PW-1:PW-2], st_q.gray[PW-3:0]};
        full_o   = (peer_gray_i == full_pat);
        empty_o  = (st_q.gray == peer_gray_i);
        pop      = pop_req_i && !empty_o;

        st_d       = st_q;
        st_d.bin   = st_q.bin + PW'(pop);
        st_d.gray  = PW'(bin2gray(dcf_ptr_t'(st_d.bin)));
        st_d.level = peer_bin - st_q.bin;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign ren_o   = pop;
    assign raddr_o = st_q.bin[ADDR_W-1:0];
    assign gray_o  = st_q.gray;

    // R10: the read Gray pointer moves by at most one bit per cycle
    p_rgray_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);

    // R9: the read pointer never runs past the synchronized write pointer
    p_no_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (peer_bin - st_q.bin) <= PW'(DEPTH));

    // R5: the registered count stays in range
    p_rlevel_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.level <= PW'(DEPTH));

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wreq,
    input  logic [DATA_W-1:0] wdata,
    output logic              wfull,
    output logic              wempty,
    output logic [ADDR_W:0]   wused,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rreq,
    output logic [DATA_W-1:0] rdata,
    output logic              rfull,
    output logic              rempty,
    output logic [ADDR_W:0]   rused
);

    localparam int unsigned PW = ADDR_W + 1;

    logic [PW-1:0]     wgray_tx, wgray_sync;
    logic [PW-1:0]     rgray, rgray_sync;
    logic              wen, ren;
    logic [ADDR_W-1:0] waddr, raddr;

    dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk_i       (wclk),
        .rst_ni      (wrst_n),
        .push_req_i  (wreq),
        .peer_gray_i (rgray_sync),
        .full_o      (wfull),
        .empty_o     (wempty),
        .level_o     (wused),
        .wen_o       (wen),
        .waddr_o     (waddr),
        .gray_tx_o   (wgray_tx)
    );

    dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk_i  (rclk),
        .rst_ni (rrst_n),
        .d_i    (wgray_tx),
        .q_o    (wgray_sync)
    );

    dcf_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk_i  (wclk),
        .rst_ni (wrst_n),
        .d_i    (rgray),
        .q_o    (rgray_sync)
    );

    dcf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk_i       (rclk),
        .rst_ni      (rrst_n),
        .pop_req_i   (rreq),
        .peer_gray_i (wgray_sync),
        .full_o      (rfull),
        .empty_o     (rempty),
        .level_o     (rused),
        .ren_o       (ren),
        .raddr_o     (raddr),
        .gray_o      (rgray)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk_i  (wclk),
        .wen_i   (wen),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .rclk_i  (rclk),
        .rrst_ni (rrst_n),
        .ren_i   (ren),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    // R6: a request refused because the buffer is empty leaves the output word alone
    p_rdata_hold_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rreq && rempty) |=> $stable(rdata));

    // R2: the write side never shows full and empty together
    p_wflags_excl_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
        !(wfull && wempty));

endmodule

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/1ps
module tb_dcf_fifo;

    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int NS    = 2;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          wrst_n, rrst_n, wreq, rreq;
    logic [DW-1:0] wdata, rdata;
    logic          wfull, wempty, rfull, rempty;
    logic [AW:0]   wused, rused;

    int      checks = 0;
    int      errors = 0;
    bit      done   = 1'b0;
    logic [DW-1:0] model [$];

    dcf_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(NS)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .wreq(wreq), .wdata(wdata),
        .wfull(wfull), .wempty(wempty), .wused(wused),
        .rclk(rclk), .rrst_n(rrst_n), .rreq(rreq), .rdata(rdata),
        .rfull(rfull), .rempty(rempty), .rused(rused)
    );

    // 100 MHz write clock on whole-ns edges; read clock edges sit on half-ns offsets
    always #5 wclk = ~wclk;
    initial begin
        #0.5;
        forever #7 rclk = ~rclk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill_val(input int i);
        return DW'(8'h10 + 3 * i);
    endfunction

    task automatic settle();
        repeat (NS + 3) @(posedge wclk);
        repeat (NS + 3) @(posedge rclk);
        #0.2;
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        wrst_n = 1'b0; rrst_n = 1'b0;
        wreq = 1'b0;  rreq = 1'b0; wdata = '0;
        repeat (3) @(posedge wclk);
        #2;
        wrst_n = 1'b1; rrst_n = 1'b1;

        // R11 reset state
        chk("R11 wempty", 32'(wempty), 1);
        chk("R11 wfull",  32'(wfull),  0);
        chk("R11 wused",  32'(wused),  0);
        chk("R11 rempty", 32'(rempty), 1);
        chk("R11 rfull",  32'(rfull),  0);
        chk("R11 rused",  32'(rused),  0);
        chk("R11 rdata",  32'(rdata),  0);

        // single write: local and cross-domain timing
        @(negedge wclk); wreq = 1'b1; wdata = 8'hA5;
        @(posedge wclk); #0.2; wreq = 1'b0;
        chk("R2 wempty after write", 32'(wempty), 0);
        chk("R3 wused one cycle after write", 32'(wused), 0);
        @(posedge wclk); #0.2;
        chk("R3 wused two cycles after write", 32'(wused), 1);
        chk("R4 rempty before sync", 32'(rempty), 1);
        repeat (NS - 1) @(posedge rclk);
        #0.2;
        chk("R4 rempty one edge early", 32'(rempty), 1);
        @(posedge rclk); #0.2;
        chk("R4 rempty after n rclk", 32'(rempty), 0);
        chk("R5 rused after n rclk", 32'(rused), 0);
        @(posedge rclk); #0.2;
        chk("R5 rused after n+1 rclk", 32'(rused), 1);

        // single read: local and cross-domain timing
        settle();
        @(negedge rclk); rreq = 1'b1;
        @(posedge rclk); #0.2; rreq = 1'b0;
        chk("R6 rdata", 32'(rdata), 32'h0A5);
        chk("R7 rempty after read", 32'(rempty), 1);
        chk("R7 rused one cycle after read", 32'(rused), 1);
        chk("R8 wempty before sync", 32'(wempty), 0);
        repeat (NS - 1) @(posedge wclk);
        #0.2;
        chk("R8 wempty one edge early", 32'(wempty), 0);
        @(posedge wclk); #0.2;
        chk("R8 wempty after n wclk", 32'(wempty), 1);
        chk("R8 wused after n wclk", 32'(wused), 1);
        @(posedge wclk); #0.2;
        chk("R8 wused after n+1 wclk", 32'(wused), 0);
        chk("R7 rused settled", 32'(rused), 0);

        // fill to the brim, then push against full
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wclk); wreq = 1'b1; wdata = fill_val(i);
            @(posedge wclk); #0.2;
            if (i == DEPTH - 2) chk("R2 wfull one short", 32'(wfull), 0);
            if (i == DEPTH - 1) begin
                chk("R2 wfull at depth", 32'(wfull), 1);
                chk("R3 wused lags one cycle", 32'(wused), DEPTH - 1);
            end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge wclk); wreq = 1'b1; wdata = 8'hEE;
            @(posedge wclk); #0.2;
            chk("R9 wfull holds under pushes", 32'(wfull), 1);
        end
        wreq = 1'b0;
        settle();
        chk("R9 wused capped", 32'(wused), DEPTH);
        chk("R4 rfull", 32'(rfull), 1);
        chk("R5 rused full", 32'(rused), DEPTH);

        // drain, checking order and read-side timing
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge rclk); rreq = 1'b1;
            @(posedge rclk); #0.2; rreq = 1'b0;
            chk("R1 drain order", 32'(rdata), 32'(fill_val(i)));
            chk("R7 rused unchanged at read edge", 32'(rused), DEPTH - i);
            if (i == 0) chk("R7 rfull after read", 32'(rfull), 0);
            chk("R7 rempty after read", 32'(rempty), (i == DEPTH - 1) ? 1 : 0);
            @(posedge rclk); #0.2;
            chk("R7 rused two cycles after read", 32'(rused), DEPTH - 1 - i);
        end
        settle();
        chk("R8 wfull cleared", 32'(wfull),  0);
        chk("R8 wempty set",    32'(wempty), 1);
        chk("R8 wused zero",    32'(wused),  0);

        // reads against an empty buffer
        for (int k = 0; k < 3; k++) begin
            @(negedge rclk); rreq = 1'b1;
            @(posedge rclk); #0.2;
            chk("R9 rdata held on empty read", 32'(rdata), 32'(fill_val(DEPTH - 1)));
            chk("R9 rused held on empty read", 32'(rused), 0);
        end
        rreq = 1'b0;
        settle();
        chk("R9 wused after empty reads", 32'(wused), 0);
        chk("R9 wempty after empty reads", 32'(wempty), 1);
        @(negedge wclk); wreq = 1'b1; wdata = 8'h3C;
        @(posedge wclk); #0.2; wreq = 1'b0;
        settle();
        @(negedge rclk); rreq = 1'b1;
        @(posedge rclk); #0.2; rreq = 1'b0;
        chk("R9 pointers intact after refusals", 32'(rdata), 32'h03C);
        chk("R9 rempty after refusals", 32'(rempty), 1);
        settle();

        // random traffic: writer-heavy then reader-heavy
        fork
            begin
                logic acc_w;
                for (int c = 0; c < 4000; c++) begin
                    @(negedge wclk);
                    wreq  = ($urandom % 100) < ((c < 2000) ? 70 : 30);
                    wdata = DW'($urandom);
                    acc_w = wreq && !wfull;
                    if (wused > DEPTH) chk("R10 wused bound", 32'(wused), DEPTH);
                    @(posedge wclk);
                    if (acc_w) model.push_back(wdata);
                end
                @(negedge wclk); wreq = 1'b0;
            end
            begin
                logic          acc_r;
                logic [DW-1:0] exp_w;
                for (int c = 0; c < 2850; c++) begin
                    @(negedge rclk);
                    rreq  = ($urandom % 100) < ((c < 1425) ? 40 : 85);
                    acc_r = rreq && !rempty;
                    if (rused > DEPTH) chk("R10 rused bound", 32'(rused), DEPTH);
                    @(posedge rclk); #0.2;
                    if (acc_r) begin
                        if (model.size() == 0) begin
                            chk("R10 read with nothing written", 0, 1);
                        end else begin
                            exp_w = model.pop_front();
                            chk("R1 random order", 32'(rdata), 32'(exp_w));
                        end
                    end
                end
                @(negedge rclk); rreq = 1'b0;
            end
        join
        settle();
        chk("R3 wused matches model", 32'(wused), 32'(model.size()));
        chk("R5 rused matches model", 32'(rused), 32'(model.size()));
        chk("R2 wempty matches model", 32'(wempty), (model.size() == 0) ? 1 : 0);
        chk("R10 rempty matches model", 32'(rempty), (model.size() == 0) ? 1 : 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule